// File: doc/BRIEF.md
# FIFO-to-Memory Transfer Sequencer

This block runs a write-then-read-back test through the user side of an external memory controller. Software-free and self-timed, it starts when `start` is pulsed in the idle state. The block latches a base address and a word count. It drains that many 512-bit words from a show-ahead input FIFO into the controller's write-data channel. In parallel it issues one write command per word on the command channel, with the address stepping by a fixed stride. When both streams have finished, it replays the same address range with read commands. Each returned word is compared against the known test pattern.

The command channel and the write-data channel are treated as two independent streams, each with its own enable/ready handshake and its own counter. Back-pressure on one stream never stalls or reorders the other. Because every command is held until it is accepted, the n-th write command is always paired with the n-th write beat. Read responses are taken only in cycles flagged valid and are assumed to return in command order. A mismatch raises a sticky error flag and records the address of the first failing word. A one-cycle `done` pulse closes the sequence.

Top module: `xfer_seq`

## Requirements
- R1: After reset and whenever `busy` is low, `cmd_en`, `wr_en`, `fifo_rd`, `done` and `err` are low, except `done` in its single pulse cycle and `err` holding a result.
- R2: The test word with index k (0-based within a run) has, in lane j (bits 32*j+31 down to 32*j, j = 0..15), the value whose top byte is 16*j and whose low 24 bits are k. Read beat n is compared against word n.
- R3: While `cmd_en` is high and `cmd_rdy` is low, the next cycle still shows `cmd_en` high with unchanged `cmd_addr` and `cmd_code`.
- R4: In the write phase, exactly `xfer_len` write commands (`cmd_code` = 0) are accepted at addresses base + i*STRIDE (STRIDE = 8) for i = 0..len-1. No read command is accepted before both the write-command count and the write-beat count have reached `xfer_len`.
- R5: `wr_en` is high only while the FIFO is not empty. `fifo_rd` is high exactly in cycles where `wr_en` and `wr_rdy` are both high. `wr_data` equals the FIFO head and `wr_end` is high on every beat.
- R6: The read phase issues exactly `xfer_len` read commands (`cmd_code` = 1), restarting from the base address and stepping by STRIDE.
- R7: `rd_data` is taken only in read-phase cycles with `rd_valid` high. `rd_valid` pulses while idle or during the write phase have no effect on `err` or the count of read beats.
- R8: A read beat that differs from its expected word sets `err`, which stays high until the next accepted start. `err_addr` holds the address of the first failing beat.
- R9: `done` is high for exactly one cycle, in the cycle after the final read beat is taken, and `busy` is low in that cycle.
- R10: `start` is ignored while `busy` is high. A start with `xfer_len` = 0 produces a `done` pulse in the next cycle and no commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| base_addr | input | 28 | First address of the run |
| xfer_len | input | 16 | Number of words in the run |
| fifo_empty | input | 1 | Input FIFO has no word |
| fifo_dout | input | 512 | Input FIFO head word (show-ahead) |
| fifo_rd | output | 1 | Pop the FIFO head |
| cmd_en | output | 1 | Command valid |
| cmd_code | output | 3 | 0 = write, 1 = read |
| cmd_addr | output | 28 | Command address |
| cmd_rdy | input | 1 | Controller accepts command |
| wr_en | output | 1 | Write beat valid |
| wr_data | output | 512 | Write beat data |
| wr_end | output | 1 | Last beat of the burst |
| wr_rdy | input | 1 | Controller accepts write beat |
| rd_data | input | 512 | Returned read word |
| rd_valid | input | 1 | Returned word valid |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle run completion pulse |
| err | output | 1 | Sticky compare mismatch |
| err_addr | output | 28 | Address of first mismatch |

## Verification
A command counter or address register that slips shows up at the very next accepted command, as an address off its base + i*STRIDE sequence. A drop of `cmd_en` during back-pressure is visible one cycle after the refused handshake. A write-beat counter out of step with the FIFO shows as a pop without an accepted beat, or as a wrong word landing at an address. After read-back, that wrong word surfaces as `err` and a non-zero `err_addr` at the `done` pulse. A read-side counter that is off changes the cycle of `done` relative to the final valid beat, or leaves `busy` stuck high.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int PAT_LANE_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_t;

  localparam logic [2:0] CMD_WR = 3'd0;
  localparam logic [2:0] CMD_RD = 3'd1;

  // One lane of the test word: top byte encodes the lane, low bits the word index.
  function automatic logic [PAT_LANE_W-1:0] lane_value(input logic [23:0] widx,
                                                       input logic [3:0]  lane);
    return {lane, 4'h0, widx};
  endfunction

  // Address of the next command in a strided sweep.
  function automatic logic [63:0] step_addr(input logic [63:0] cur, input int unsigned stride);
    return cur + 64'(stride);
  endfunction

endpackage

// File: rtl/xfer_cmd_issuer.sv
module xfer_cmd_issuer #(
  parameter int ADDR_W = 28,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              rdy,
  output logic              en,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  cnt,
  output logic              fire
);
  import xfer_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt_q;

  // The command stays presented with the same address until accepted.
  assign en   = active && (cnt_q != len);
  assign fire = en && rdy;
  assign addr = addr_q;
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (restart) begin
      addr_q <= base;
      cnt_q  <= '0;
    end else if (fire) begin
      addr_q <= ADDR_W'(step_addr(64'(addr_q), STRIDE));
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/xfer_wdata_feeder.sv
module xfer_wdata_feeder #(
  parameter int DATA_W = 512,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic [LEN_W-1:0]  len,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_dout,
  input  logic              wr_rdy,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_end,
  output logic              fifo_rd,
  output logic [LEN_W-1:0]  cnt,
  output logic              fire
);
  logic [LEN_W-1:0] cnt_q;

  // Each command carries a single beat, so every beat closes its burst.
  assign wr_en   = active && !fifo_empty && (cnt_q != len);
  assign wr_data = fifo_dout;
  assign wr_end  = wr_en;
  assign fire    = wr_en && wr_rdy;
  assign fifo_rd = fire;
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (fire)    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/xfer_rd_checker.sv
module xfer_rd_checker #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 28,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 8,
  localparam int DATA_W = LANES * xfer_pkg::PAT_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  cnt,
  output logic              fire,
  output logic              last,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr
);
  import xfer_pkg::*;

  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] chk_addr_q;
  logic [DATA_W-1:0] exp_word;
  logic              err_q;
  logic [ADDR_W-1:0] err_addr_q;
  logic              mismatch;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign exp_word[j*PAT_LANE_W +: PAT_LANE_W] = lane_value(24'(cnt_q), 4'(j));
  end

  assign fire     = active && rd_valid;
  assign last     = fire && (cnt_q == len - 1'b1);
  assign mismatch = fire && (rd_data != exp_word);
  assign cnt      = cnt_q;
  assign err      = err_q;
  assign err_addr = err_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      chk_addr_q <= '0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else if (restart) begin
      cnt_q      <= '0;
      chk_addr_q <= base;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else if (fire) begin
      cnt_q      <= cnt_q + 1'b1;
      chk_addr_q <= ADDR_W'(step_addr(64'(chk_addr_q), STRIDE));
      if (mismatch && !err_q) begin
        err_q      <= 1'b1;
        err_addr_q <= chk_addr_q;
      end
    end
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 28,
  parameter int LEN_W  = 16,
  parameter int STRIDE = 8,
  localparam int DATA_W = LANES * xfer_pkg::PAT_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_dout,
  output logic              fifo_rd,
  output logic              cmd_en,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rdy,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_end,
  input  logic              wr_rdy,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr
);
  import xfer_pkg::*;

  phase_t            phase;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q;

  // Named internal events, also observed by the bound checker.
  logic              start_go;
  logic              to_read;
  logic              cmd_restart;
  logic [ADDR_W-1:0] cmd_base;
  logic              cmd_fire, wr_fire, rd_fire, rd_last;
  logic [LEN_W-1:0]  cmd_cnt, wr_cnt, rd_cnt;

  assign start_go    = (phase == PH_IDLE) && start;
  assign to_read     = (phase == PH_WRITE) && (cmd_cnt == len_q) && (wr_cnt == len_q);
  assign cmd_restart = start_go || to_read;
  assign cmd_base    = start_go ? base_addr : base_q;

  xfer_cmd_issuer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE(STRIDE)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cmd_restart),
    .active  (phase != PH_IDLE),
    .base    (cmd_base),
    .len     (len_q),
    .rdy     (cmd_rdy),
    .en      (cmd_en),
    .addr    (cmd_addr),
    .cnt     (cmd_cnt),
    .fire    (cmd_fire)
  );

  xfer_wdata_feeder #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_wdat (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start_go),
    .active     (phase == PH_WRITE),
    .len        (len_q),
    .fifo_empty (fifo_empty),
    .fifo_dout  (fifo_dout),
    .wr_rdy     (wr_rdy),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_end     (wr_end),
    .fifo_rd    (fifo_rd),
    .cnt        (wr_cnt),
    .fire       (wr_fire)
  );

  xfer_rd_checker #(.LANES(LANES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE(STRIDE)) u_rchk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_go),
    .active   (phase == PH_READ),
    .base     (base_addr),
    .len      (len_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cnt      (rd_cnt),
    .fire     (rd_fire),
    .last     (rd_last),
    .err      (err),
    .err_addr (err_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      len_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          len_q  <= xfer_len;
          base_q <= base_addr;
          if (xfer_len == '0) done_q <= 1'b1;
          else                phase  <= PH_WRITE;
        end
        PH_WRITE: if (to_read) phase <= PH_READ;
        PH_READ: if (rd_last) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cmd_code = (phase == PH_READ) ? CMD_RD : CMD_WR;
  assign busy     = (phase != PH_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int ADDR_W = 28,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_en,
  input logic              cmd_rdy,
  input logic [2:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wr_en,
  input logic              wr_rdy,
  input logic              wr_end,
  input logic              fifo_rd,
  input logic              fifo_empty,
  input logic              rd_valid,
  input xfer_pkg::phase_t  phase,
  input logic [LEN_W-1:0]  len_q,
  input logic [LEN_W-1:0]  cmd_cnt,
  input logic [LEN_W-1:0]  wr_cnt,
  input logic [LEN_W-1:0]  rd_cnt
);
  import xfer_pkg::*;

  logic in_read;
  assign in_read = (phase == PH_READ);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_en && !wr_en && !fifo_rd));                                  // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_rdy) |=> (cmd_en && $stable(cmd_addr) && $stable(cmd_code))); // R3

  AST_PHASE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) |-> ($past(cmd_cnt) == len_q && $past(wr_cnt) == len_q));       // R4

  AST_POP_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (wr_en && wr_rdy && !fifo_empty));                               // R5

  AST_BEAT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_end);                                                            // R5

  AST_READ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && in_read) |=> $stable(rd_cnt));                                  // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> err);                                          // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                              // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                              // R9

endmodule

bind xfer_seq xfer_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .cmd_en     (cmd_en),
  .cmd_rdy    (cmd_rdy),
  .cmd_code   (cmd_code),
  .cmd_addr   (cmd_addr),
  .wr_en      (wr_en),
  .wr_rdy     (wr_rdy),
  .wr_end     (wr_end),
  .fifo_rd    (fifo_rd),
  .fifo_empty (fifo_empty),
  .rd_valid   (rd_valid),
  .phase      (phase),
  .len_q      (len_q),
  .cmd_cnt    (cmd_cnt),
  .wr_cnt     (wr_cnt),
  .rd_cnt     (rd_cnt)
);

// File: tb/sim_xfer_seq.sv
`timescale 1ns/1ps
module sim_xfer_seq;
  localparam int AW = 28;
  localparam int LW = 16;
  localparam int DW = 512;
  localparam int STR = 8;

  // Vector table: length, base slot, corrupted word index (-1 none), FIFO gaps, ready percent
  localparam int NV = 6;
  localparam int T_LEN  [NV] = '{4, 12, 16, 7, 32, 20};
  localparam int T_SLOT [NV] = '{0, 10, 40, 3, 100, 60};
  localparam int T_BAD  [NV] = '{-1, -1, 5, 0, -1, 19};
  localparam int T_GAP  [NV] = '{0, 0, 1, 0, 1, 0};
  localparam int T_PCT  [NV] = '{100, 50, 35, 70, 60, 25};

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic fifo_empty = 1;
  logic [DW-1:0] fifo_dout = '0;
  logic fifo_rd, cmd_en, wr_en, wr_end, busy, done, err;
  logic [2:0] cmd_code;
  logic [AW-1:0] cmd_addr, err_addr;
  logic cmd_rdy = 0, wr_rdy = 0, rd_valid = 0;
  logic [DW-1:0] wr_data, rd_data = '0;

  always #5 clk = ~clk;

  xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .xfer_len(xfer_len),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_rd(fifo_rd),
    .cmd_en(cmd_en), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_rdy(cmd_rdy),
    .wr_en(wr_en), .wr_data(wr_data), .wr_end(wr_end), .wr_rdy(wr_rdy),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .err(err), .err_addr(err_addr)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Test word k: lane j = {top byte 16*j, low 24 bits k}
  function automatic logic [DW-1:0] pat(input int k);
    logic [DW-1:0] w;
    for (int j = 0; j < 16; j++) w[j*32 +: 32] = (32'(j) << 28) | (32'(k) & 32'h00FF_FFFF);
    return w;
  endfunction

  // Stub state
  logic [DW-1:0] fifo_q[$];
  logic [DW-1:0] wdq[$];
  int wcq[$];
  int rq[$];
  logic [DW-1:0] mem [0:255];
  int cyc = 0, pct = 100, junk = 0;
  int cur_len = 0, cur_base = 0, cur_bad = -1;
  int feed_left = 0, feed_idx = 0, feed_gap = 0;
  int wcmd = 0, wbeats = 0, rcmd = 0, rbeats = 0, mon_bad = 0, last_rv_cyc = 0;
  bit pop_pend = 0, hold_prev = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [2:0] prev_code = '0;

  function automatic logic [DW-1:0] word_for(input int k);
    return pat(k) ^ ((k == cur_bad) ? DW'(1) : DW'(0));
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pop_pend) begin void'(fifo_q.pop_front()); pop_pend = 0; end
    if (feed_left > 0 && (feed_gap == 0 || cyc % 3 == 0)) begin
      fifo_q.push_back(word_for(feed_idx)); feed_idx++; feed_left--;
    end
    fifo_empty = (fifo_q.size() == 0);
    fifo_dout  = fifo_empty ? '0 : fifo_q[0];
    cmd_rdy = ($urandom_range(99) < pct);
    wr_rdy  = ($urandom_range(99) < pct);
    rd_valid = 0; rd_data = '0;
    if (rq.size() > 0 && $urandom_range(99) < pct) begin
      rd_valid = 1; rd_data = mem[rq.pop_front()]; rbeats++; last_rv_cyc = cyc;
    end else if ((junk == 1 && busy && wbeats < cur_len) || junk == 2) begin
      rd_valid = 1; rd_data = {DW{1'b1}};
    end
    #1;
    if (hold_prev && !(cmd_en && cmd_addr == prev_addr && cmd_code == prev_code)) mon_bad++; // R3
    hold_prev = cmd_en && !cmd_rdy; prev_addr = cmd_addr; prev_code = cmd_code;
    if (cmd_en && cmd_rdy) begin
      if (cmd_code == 3'd0) begin                                        // R4
        if (int'(cmd_addr) != cur_base + wcmd*STR) mon_bad++;
        wcq.push_back((int'(cmd_addr) / STR) % 256); wcmd++;
      end else if (cmd_code == 3'd1) begin                               // R6
        if (wcmd != cur_len || wbeats != cur_len) mon_bad++;
        if (int'(cmd_addr) != cur_base + rcmd*STR) mon_bad++;
        rq.push_back((int'(cmd_addr) / STR) % 256); rcmd++;
      end else mon_bad++;
    end
    if (wr_en && wr_rdy) begin                                           // R5
      if (!fifo_rd || wr_end !== 1'b1 || fifo_q.size() == 0 || wr_data != fifo_q[0]) mon_bad++;
      wdq.push_back(wr_data); wbeats++; pop_pend = 1;
    end else if (fifo_rd) mon_bad++;
    if (wr_en && fifo_empty) mon_bad++;
    while (wcq.size() > 0 && wdq.size() > 0) mem[wcq.pop_front()] = wdq.pop_front();
  end

  task automatic tick; @(posedge clk); #2; endtask

  task automatic run_case(input int len, input int slot, input int bad, input int gap,
                          input int p, input bit poke, input int jk);
    int done_cyc = -1;
    bit done_twice = 0;
    cur_len = len; cur_base = slot*STR; cur_bad = bad;
    wcmd = 0; wbeats = 0; rcmd = 0; rbeats = 0; mon_bad = 0; pct = p; junk = jk;
    feed_idx = 0; feed_gap = gap; feed_left = len;
    start = 1; base_addr = AW'(cur_base); xfer_len = LW'(len);
    tick;
    start = 0;
    for (int i = 0; i < 20000; i++) begin
      if (poke && i == 3) begin start = 1; base_addr = AW'(200*STR); xfer_len = 5; end
      else start = 0;
      tick;
      if (done) begin done_cyc = cyc; break; end
    end
    start = 0; junk = 0;
    check(done_cyc >= 0, "R9", "done seen", done_cyc, 1);
    check(done_cyc == last_rv_cyc, "R9", "done one cycle after last beat", done_cyc, last_rv_cyc);
    check(!busy, "R9", "busy low with done", busy, 0);
    check(wcmd == len && wbeats == len, "R4", "write commands/beats", wcmd*1000+wbeats, len*1000+len);
    check(rcmd == len && rbeats == len, "R6", "read commands/beats", rcmd*1000+rbeats, len*1000+len);
    check(mon_bad == 0, "R3", "handshake/address protocol violations", mon_bad, 0);
    check(fifo_q.size() == 0, "R5", "FIFO drained", fifo_q.size(), 0);
    check(err == (bad >= 0), "R8", "err flag", err, (bad >= 0));
    if (bad >= 0) check(int'(err_addr) == cur_base + bad*STR, "R8", "err_addr", err_addr, cur_base + bad*STR);
    else          check(err_addr == '0, "R2", "clean pattern err_addr", err_addr, 0);
    tick;
    if (done) done_twice = 1;
    check(!done_twice, "R9", "done single cycle", done_twice, 0);
    if (poke) check(rcmd == len, "R10", "start while busy ignored", rcmd, len);
  endtask

  initial begin
    #1500000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) tick;
    check(!busy && !done && !err, "R1", "in reset", {busy, done, err}, 0);
    rst_n = 1;
    tick;
    check(!busy && !done && !err, "R1", "after reset status", {busy, done, err}, 0);
    check(!cmd_en && !wr_en && !fifo_rd, "R1", "after reset channels", {cmd_en, wr_en, fifo_rd}, 0);

    for (int v = 0; v < NV; v++)
      run_case(T_LEN[v], T_SLOT[v], T_BAD[v], T_GAP[v], T_PCT[v], 0, 0);

    // Zero length: done next cycle, no commands
    wcmd = 0; rcmd = 0; cur_len = 0;
    start = 1; xfer_len = 0; base_addr = AW'(5*STR);
    tick; start = 0;
    check(done && !busy, "R10", "zero-length done", done, 1);
    repeat (4) tick;
    check(wcmd == 0 && rcmd == 0 && !cmd_en, "R10", "zero-length issues nothing", wcmd + rcmd, 0);

    // Start pulse during a run
    run_case(10, 20, -1, 0, 40, 1, 0);

    // Junk read-valid during write phase
    run_case(8, 30, -1, 1, 50, 0, 1);
    check(!err, "R7", "junk during write ignored", err, 0);

    // Junk read-valid while idle
    junk = 2; repeat (5) tick; junk = 0; tick;
    check(!err && !busy && !done, "R7", "junk while idle ignored", {err, busy, done}, 0);

    // An error is cleared by the next start
    run_case(6, 70, 2, 0, 80, 0, 0);
    run_case(6, 70, -1, 0, 80, 0, 0);
    check(!err, "R8", "err cleared on new start", err, 0);

    // Inspect an individual returned pattern lane
    check(pat(7)[15*32 +: 32] == 32'hF000_0007, "R2", "pattern lane 15 of word 7",
          pat(7)[15*32 +: 32], 32'hF000_0007);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule